// File: doc/BRIEF.md
# Block-Transfer DMA Engine

This block copies a block of words between a peripheral word stream and a synchronous memory port without processor involvement. Software programs a start address and a word count, then writes the control register with the direction and the start bit. For each word the engine performs one memory access with a request/acknowledge handshake, advances the address, and decrements the count of words still to move. When the block is complete it raises a completion flag and, if enabled, an interrupt.

In the memory-to-device direction every word is read from memory and then offered on an outgoing valid/ready stream. In the device-to-memory direction every word taken from an incoming valid/ready stream is then written to memory. The programmed start address and count are copied into working registers at start, so software may prepare the next block while the current one runs.

Top module: `blkmove_dma`

## Requirements
- R1: After reset all registers and flags read 0, and `mem_req`, `pout_valid`, `pin_ready` and `irq_o` are 0.
- R2: Register offsets on `cfg_addr`: 0 start address, 1 word count, 2 control, 3 words remaining (read only). Control bits: bit0 start (write only), bit1 direction, bit2 interrupt enable, bit3 done (read only), bit4 interrupt pending. Offsets 0 and 1 read back what was written, and direction and enable read back in control.
- R3: A control write with bit0 = 1 while the engine is idle clears done and the pending interrupt and loads the working address and count. The same write while a block is running is ignored.
- R4: With direction 1, words are read from consecutive memory addresses starting at the start address, and each is then offered on the outgoing stream, in address order.
- R5: With direction 0, each word accepted from the incoming stream is written to the next consecutive memory address, starting at the start address.
- R6: `mem_req` remains high with `mem_addr`, `mem_we` and `mem_wdata` stable until `mem_ack`. The address and the remaining count advance only on an acknowledged access.
- R7: `pout_valid` remains high with `pout_data` stable until `pout_ready`. At most one of `mem_req`, `pout_valid` and `pin_ready` is high in any cycle.
- R8: Done goes to 1 once the last word has completed: after the device accepts it with direction 1, or after its write is acknowledged with direction 0. The number of memory accesses equals the programmed count, and the remaining count then reads 0.
- R9: A start with a word count of 0 sets done in the cycle after the write and performs no memory access.
- R10: When a block completes with interrupt enable at 1, the pending bit is set. `irq_o` is the pending bit ANDed with interrupt enable. Writing 1 to control bit4 clears the pending bit.
- R11: Writes to the start address and word count while a block is running do not affect that block. They take effect at the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register offset |
| cfg_wdata | input | DATA_W | Register write data |
| cfg_rdata | output | DATA_W | Register read data (combinational on cfg_addr) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Memory access acknowledge |
| mem_rdata | input | DATA_W | Memory read data, valid with mem_ack |
| pout_valid | output | 1 | Outgoing word valid |
| pout_data | output | DATA_W | Outgoing word |
| pout_ready | input | 1 | Device accepts outgoing word |
| pin_valid | input | 1 | Incoming word valid |
| pin_data | input | DATA_W | Incoming word |
| pin_ready | output | 1 | Engine accepts incoming word |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check the handshake rules on every cycle. A waiting memory request must keep its address, direction and data. A waiting outgoing word must stay put. Only one port may be active at a time. Done must clear on a real start, and at completion the number of acknowledged accesses must equal the programmed count. Only the bench scenarios can show the values themselves: which addresses are visited, the data order in both directions, that a start or register write during a running block is ignored, and how the pending bit and enable combine at `irq_o`.

// File: rtl/blkmove_pkg.sv
package blkmove_pkg;

   typedef enum logic [2:0] {
      WK_IDLE  = 3'd0,
      WK_FETCH = 3'd1,
      WK_PUSH  = 3'd2,
      WK_PULL  = 3'd3,
      WK_STORE = 3'd4
   } walk_state_t;

   localparam int SEL_W = 2;

   localparam logic [SEL_W-1:0] OFS_BASE  = 2'd0;
   localparam logic [SEL_W-1:0] OFS_COUNT = 2'd1;
   localparam logic [SEL_W-1:0] OFS_CTRL  = 2'd2;
   localparam logic [SEL_W-1:0] OFS_LEFT  = 2'd3;

   localparam int BIT_START = 0;
   localparam int BIT_DIR   = 1;
   localparam int BIT_IE    = 2;
   localparam int BIT_DONE  = 3;
   localparam int BIT_IRQ   = 4;
   localparam int CTRL_BITS = 5;

endpackage

// File: rtl/blkmove_csr.sv
module blkmove_csr
   import blkmove_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 12,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [SEL_W-1:0]  cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [DATA_W-1:0] cfg_rdata,
   input  logic              idle_i,
   input  logic              fin_i,
   input  logic [CNT_W-1:0]  left_i,
   output logic [ADDR_W-1:0] base_o,
   output logic [CNT_W-1:0]  count_o,
   output logic              count_zero_o,
   output logic              dir_o,
   output logic              ie_o,
   output logic              go_o,
   output logic              done_o,
   output logic              irq_flag_o,
   output logic              irq_o
);

   logic [ADDR_W-1:0] base_q;
   logic [CNT_W-1:0]  count_q;
   logic              dir_q, ie_q, done_q, irq_q;
   logic              ctrl_wr, start_req, ie_eff;
   logic [DATA_W-1:0] ctrl_view;
   logic              unused_wbits;

   assign ctrl_wr   = cfg_we && (cfg_addr == OFS_CTRL);
   assign start_req = ctrl_wr && cfg_wdata[BIT_START];
   assign go_o      = start_req && idle_i;
   assign dir_o     = ctrl_wr ? cfg_wdata[BIT_DIR] : dir_q;
   assign ie_eff    = ctrl_wr ? cfg_wdata[BIT_IE]  : ie_q;

   assign unused_wbits = ^cfg_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q  <= '0;
         count_q <= '0;
         dir_q   <= 1'b0;
         ie_q    <= 1'b0;
      end else if (cfg_we) begin
         case (cfg_addr)
            OFS_BASE:  base_q  <= cfg_wdata[ADDR_W-1:0];
            OFS_COUNT: count_q <= cfg_wdata[CNT_W-1:0];
            OFS_CTRL: begin
               dir_q <= cfg_wdata[BIT_DIR];
               ie_q  <= cfg_wdata[BIT_IE];
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q <= 1'b0;
      end else if (fin_i) begin
         done_q <= 1'b1;
      end else if (go_o) begin
         done_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
      end else if (fin_i && ie_eff) begin
         irq_q <= 1'b1;
      end else if (go_o) begin
         irq_q <= 1'b0;
      end else if (ctrl_wr && cfg_wdata[BIT_IRQ]) begin
         irq_q <= 1'b0;
      end
   end

   always_comb begin
      ctrl_view            = '0;
      ctrl_view[BIT_DIR]   = dir_q;
      ctrl_view[BIT_IE]    = ie_q;
      ctrl_view[BIT_DONE]  = done_q;
      ctrl_view[BIT_IRQ]   = irq_q;
   end

   always_comb begin
      case (cfg_addr)
         OFS_BASE:  cfg_rdata = DATA_W'(base_q);
         OFS_COUNT: cfg_rdata = DATA_W'(count_q);
         OFS_CTRL:  cfg_rdata = ctrl_view;
         default:   cfg_rdata = DATA_W'(left_i);
      endcase
   end

   assign base_o       = base_q;
   assign count_o      = count_q;
   assign count_zero_o = (count_q == '0);
   assign ie_o         = ie_q;
   assign done_o       = done_q;
   assign irq_flag_o   = irq_q;
   assign irq_o        = irq_q & ie_q;

endmodule

// File: rtl/blkmove_walker.sv
module blkmove_walker #(
   parameter int ADDR_W     = 16,
   parameter int CNT_W      = 12,
   parameter int WORD_BYTES = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [CNT_W-1:0]  count_i,
   input  logic              step_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic [CNT_W-1:0]  left_o,
   output logic              last_o
);

   logic [ADDR_W-1:0] addr_q;
   logic [CNT_W-1:0]  left_q;
   logic [ADDR_W-1:0] stride;

   generate
      if ((WORD_BYTES & (WORD_BYTES - 1)) != 0) begin : g_bad_stride
         $error("blkmove_walker: WORD_BYTES must be a power of two");
      end
      if (WORD_BYTES == 1) begin : g_word_addr
         assign stride = ADDR_W'(1);
      end else begin : g_byte_addr
         assign stride = ADDR_W'(WORD_BYTES);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         left_q <= '0;
      end else if (load_i) begin
         addr_q <= base_i;
         left_q <= count_i;
      end else if (step_i) begin
         addr_q <= addr_q + stride;
         left_q <= left_q - CNT_W'(1);
      end
   end

   assign addr_o = addr_q;
   assign left_o = left_q;
   assign last_o = (left_q == CNT_W'(1));

endmodule

// File: rtl/blkmove_fsm.sv
module blkmove_fsm
   import blkmove_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go_i,
   input  logic              dir_i,
   input  logic              count_zero_i,
   input  logic              last_i,
   input  logic              mem_ack_i,
   input  logic [DATA_W-1:0] mem_rdata_i,
   input  logic              pout_ready_i,
   input  logic              pin_valid_i,
   input  logic [DATA_W-1:0] pin_data_i,
   output logic              load_o,
   output logic              step_o,
   output logic              fin_o,
   output logic              idle_o,
   output logic              mem_req_o,
   output logic              mem_we_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   output logic              pout_valid_o,
   output logic [DATA_W-1:0] pout_data_o,
   output logic              pin_ready_o
);

   walk_state_t       state_q;
   logic [DATA_W-1:0] word_q;
   logic              final_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= WK_IDLE;
         word_q  <= '0;
         final_q <= 1'b0;
      end else begin
         case (state_q)
            WK_IDLE: begin
               if (go_i && !count_zero_i) begin
                  state_q <= dir_i ? WK_FETCH : WK_PULL;
               end
            end
            WK_FETCH: begin
               if (mem_ack_i) begin
                  word_q  <= mem_rdata_i;
                  final_q <= last_i;
                  state_q <= WK_PUSH;
               end
            end
            WK_PUSH: begin
               if (pout_ready_i) begin
                  state_q <= final_q ? WK_IDLE : WK_FETCH;
               end
            end
            WK_PULL: begin
               if (pin_valid_i) begin
                  word_q  <= pin_data_i;
                  state_q <= WK_STORE;
               end
            end
            WK_STORE: begin
               if (mem_ack_i) begin
                  state_q <= last_i ? WK_IDLE : WK_PULL;
               end
            end
            default: state_q <= WK_IDLE;
         endcase
      end
   end

   always_comb begin
      idle_o       = (state_q == WK_IDLE);
      mem_req_o    = (state_q == WK_FETCH) || (state_q == WK_STORE);
      mem_we_o     = (state_q == WK_STORE);
      pout_valid_o = (state_q == WK_PUSH);
      pin_ready_o  = (state_q == WK_PULL);
      load_o       = go_i && idle_o;
      step_o       = mem_req_o && mem_ack_i;
      fin_o        = (go_i && idle_o && count_zero_i)
                   || ((state_q == WK_PUSH) && pout_ready_i && final_q)
                   || ((state_q == WK_STORE) && mem_ack_i && last_i);
   end

   assign mem_wdata_o = word_q;
   assign pout_data_o = word_q;

endmodule

// File: rtl/blkmove_dma.sv
module blkmove_dma
   import blkmove_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 32,
   parameter int CNT_W      = 12,
   parameter int WORD_BYTES = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [DATA_W-1:0] cfg_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              pout_valid,
   output logic [DATA_W-1:0] pout_data,
   input  logic              pout_ready,
   input  logic              pin_valid,
   input  logic [DATA_W-1:0] pin_data,
   output logic              pin_ready,
   output logic              irq_o
);

   generate
      if (DATA_W < CTRL_BITS) begin : g_bad_data
         $error("blkmove_dma: DATA_W too narrow for the control register");
      end
      if (ADDR_W > DATA_W) begin : g_bad_addr
         $error("blkmove_dma: ADDR_W must not exceed DATA_W");
      end
      if (CNT_W > DATA_W || CNT_W < 1) begin : g_bad_cnt
         $error("blkmove_dma: CNT_W must lie in 1..DATA_W");
      end
   endgenerate

   logic [ADDR_W-1:0] base_w;
   logic [CNT_W-1:0]  count_w, left_w;
   logic              count_zero_w, dir_w, ie_w;
   logic              go_w, done_w, irq_flag_w;
   logic              idle_w, fin_w, load_w, step_w, last_w;

   blkmove_csr #(
      .ADDR_W (ADDR_W),
      .CNT_W  (CNT_W),
      .DATA_W (DATA_W)
   ) i_csr (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_we       (cfg_we),
      .cfg_addr     (cfg_addr),
      .cfg_wdata    (cfg_wdata),
      .cfg_rdata    (cfg_rdata),
      .idle_i       (idle_w),
      .fin_i        (fin_w),
      .left_i       (left_w),
      .base_o       (base_w),
      .count_o      (count_w),
      .count_zero_o (count_zero_w),
      .dir_o        (dir_w),
      .ie_o         (ie_w),
      .go_o         (go_w),
      .done_o       (done_w),
      .irq_flag_o   (irq_flag_w),
      .irq_o        (irq_o)
   );

   blkmove_walker #(
      .ADDR_W     (ADDR_W),
      .CNT_W      (CNT_W),
      .WORD_BYTES (WORD_BYTES)
   ) i_walker (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (load_w),
      .base_i  (base_w),
      .count_i (count_w),
      .step_i  (step_w),
      .addr_o  (mem_addr),
      .left_o  (left_w),
      .last_o  (last_w)
   );

   blkmove_fsm #(
      .DATA_W (DATA_W)
   ) i_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .go_i         (go_w),
      .dir_i        (dir_w),
      .count_zero_i (count_zero_w),
      .last_i       (last_w),
      .mem_ack_i    (mem_ack),
      .mem_rdata_i  (mem_rdata),
      .pout_ready_i (pout_ready),
      .pin_valid_i  (pin_valid),
      .pin_data_i   (pin_data),
      .load_o       (load_w),
      .step_o       (step_w),
      .fin_o        (fin_w),
      .idle_o       (idle_w),
      .mem_req_o    (mem_req),
      .mem_we_o     (mem_we),
      .mem_wdata_o  (mem_wdata),
      .pout_valid_o (pout_valid),
      .pout_data_o  (pout_data),
      .pin_ready_o  (pin_ready)
   );

endmodule

// File: rtl/blkmove_dma_chk.sv
module blkmove_dma_chk #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_req,
   input logic              mem_ack,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic              pout_valid,
   input logic              pout_ready,
   input logic [DATA_W-1:0] pout_data,
   input logic              pin_ready,
   input logic              go,
   input logic              done,
   input logic [CNT_W-1:0]  count_cfg,
   input logic              ie,
   input logic              irq_flag
);

   logic [CNT_W-1:0] acc_q, exp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         exp_q <= '0;
      end else if (go) begin
         acc_q <= '0;
         exp_q <= count_cfg;
      end else if (mem_req && mem_ack) begin
         acc_q <= acc_q + CNT_W'(1);
      end
   end

   AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R6

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      pout_valid && !pout_ready |=> pout_valid && $stable(pout_data)); // R7

   AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_req, pout_valid, pin_ready})); // R7

   AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      go && (count_cfg != '0) |=> !done); // R3

   AST_ZERO_IMMED: assert property (@(posedge clk) disable iff (!rst_n)
      go && (count_cfg == '0) |=> done && !mem_req); // R9

   AST_ACC_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> (acc_q == exp_q)); // R8

   AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) && ie |-> irq_flag); // R10

endmodule

bind blkmove_dma blkmove_dma_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .CNT_W  (CNT_W)
) i_blkmove_dma_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mem_req    (mem_req),
   .mem_ack    (mem_ack),
   .mem_we     (mem_we),
   .mem_addr   (mem_addr),
   .mem_wdata  (mem_wdata),
   .pout_valid (pout_valid),
   .pout_ready (pout_ready),
   .pout_data  (pout_data),
   .pin_ready  (pin_ready),
   .go         (go_w),
   .done       (done_w),
   .count_cfg  (count_w),
   .ie         (ie_w),
   .irq_flag   (irq_flag_w)
);

// File: tb/test_blkmove_dma.sv
module test_blkmove_dma;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_addr = 2'd0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        mem_req, mem_we;
   logic [15:0] mem_addr;
   logic [31:0] mem_wdata;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        pout_valid;
   logic [31:0] pout_data;
   logic        pout_ready = 1'b0;
   logic        pin_valid = 1'b0;
   logic [31:0] pin_data = '0;
   logic        pin_ready;
   logic        irq_o;

   int checks = 0;
   int fails = 0;

   logic [31:0] ram [0:255];
   int exp_addr = 0;
   bit exp_we = 1'b0;
   int acc_total = 0;
   int out_base = 0;
   int out_idx = 0;
   int in_idx = 0;
   int in_cnt = 0;
   bit dev_hold = 1'b0;
   logic [7:0] lfsr = 8'h5b;
   int cyc = 0;

   always #(CLK_P/2) clk = ~clk;

   blkmove_dma i_blkmove_dma (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata), .pout_valid(pout_valid),
      .pout_data(pout_data), .pout_ready(pout_ready), .pin_valid(pin_valid),
      .pin_data(pin_data), .pin_ready(pin_ready), .irq_o(irq_o)
   );

   function automatic logic [31:0] ram_init(int a);
      return 32'hC0DE_0000 ^ (a * 32'h0000_0101);
   endfunction

   function automatic logic [31:0] src_word(int i);
      return 32'h5EED_0000 + i * 17;
   endfunction

   task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, exp);
      end
   endtask

   task automatic cfg_write(logic [1:0] a, logic [31:0] d);
      @(posedge clk); #1;
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(posedge clk); #1;
      cfg_we = 1'b0;
   endtask

   task automatic cfg_read(logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      cfg_addr = a;
      #1 d = cfg_rdata;
   endtask

   task automatic wait_done(string tag);
      logic [31:0] v;
      bit seen = 1'b0;
      for (int i = 0; i < 2000; i++) begin
         cfg_read(2'd2, v);
         if (v[3]) begin seen = 1'b1; break; end
      end
      chk(seen, tag, "done reached", {31'd0, seen}, 32'd1);
   endtask

   // memory model: acknowledges with pseudo-random wait, checks address sequence (R6)
   initial begin
      bit complete, start_ack;
      forever begin
         @(negedge clk);
         complete  = mem_req && mem_ack;
         start_ack = mem_req && !mem_ack && (lfsr[1:0] != 2'b00);
         if (complete) begin
            chk(mem_addr == exp_addr[15:0], "R6", "memory address", {16'd0, mem_addr}, exp_addr);
            chk(mem_we == exp_we, "R4", "memory direction", {31'd0, mem_we}, {31'd0, exp_we});
            if (mem_we) ram[mem_addr[7:0]] = mem_wdata;
            exp_addr++;
            acc_total++;
         end
         @(posedge clk); #1;
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         cyc++;
         if (complete) mem_ack = 1'b0;
         else if (start_ack) begin
            mem_ack = 1'b1;
            mem_rdata = ram[mem_addr[7:0]];
         end
      end
   end

   // outgoing stream sink (R4)
   initial begin
      forever begin
         @(negedge clk);
         if (pout_valid && pout_ready) begin
            chk(pout_data == ram_init(out_base + out_idx), "R4", "outgoing word",
                pout_data, ram_init(out_base + out_idx));
            out_idx++;
         end
         @(posedge clk); #1;
         pout_ready = !dev_hold && ((cyc % 3) != 1);
      end
   end

   // incoming stream source (R5)
   initial begin
      bit taken;
      forever begin
         @(negedge clk);
         taken = pin_valid && pin_ready;
         @(posedge clk); #1;
         if (taken) in_idx++;
         pin_valid = (in_idx < in_cnt) && ((cyc % 4) != 2);
         pin_data  = src_word(in_idx);
      end
   end

   initial begin
      #(CLK_P * 200000);
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      logic [31:0] v;
      int acc0;
      for (int a = 0; a < 256; a++) ram[a] = ram_init(a);
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset state
      @(negedge clk);
      chk(!mem_req && !pout_valid && !pin_ready, "R1", "idle ports",
          {29'd0, mem_req, pout_valid, pin_ready}, 32'd0);
      chk(irq_o == 1'b0, "R1", "irq_o", {31'd0, irq_o}, 32'd0);
      for (int r = 0; r < 4; r++) begin
         cfg_read(r[1:0], v);
         chk(v == 32'd0, "R1", "register after reset", v, 32'd0);
      end

      // R2: readback
      cfg_write(2'd0, 32'h0000_0010);
      cfg_write(2'd1, 32'd5);
      cfg_write(2'd2, 32'h0000_0006);
      cfg_read(2'd0, v); chk(v == 32'h10, "R2", "start address readback", v, 32'h10);
      cfg_read(2'd1, v); chk(v == 32'd5, "R2", "count readback", v, 32'd5);
      cfg_read(2'd2, v); chk(v == 32'h6, "R2", "control readback", v, 32'h6);

      // R4 R8 R10: memory to device, 5 words, interrupt enabled
      exp_addr = 16; exp_we = 1'b0; out_base = 16; out_idx = 0; acc0 = acc_total;
      cfg_write(2'd2, 32'h0000_0007);
      wait_done("R8");
      chk(out_idx == 5, "R4", "words delivered", out_idx, 5);
      chk(acc_total - acc0 == 5, "R8", "memory accesses", acc_total - acc0, 5);
      cfg_read(2'd3, v); chk(v == 32'd0, "R8", "remaining count", v, 32'd0);
      cfg_read(2'd2, v); chk(v[4] == 1'b1, "R10", "pending bit set", v, 32'h10);
      chk(irq_o == 1'b1, "R10", "irq_o asserted", {31'd0, irq_o}, 32'd1);

      // R10: masking and write-1-to-clear
      cfg_write(2'd2, 32'h0000_0002);
      @(negedge clk);
      chk(irq_o == 1'b0, "R10", "irq_o masked", {31'd0, irq_o}, 32'd0);
      cfg_read(2'd2, v); chk(v[4] == 1'b1, "R10", "pending kept while masked", v, 32'h10);
      cfg_write(2'd2, 32'h0000_0006);
      @(negedge clk);
      chk(irq_o == 1'b1, "R10", "irq_o unmasked", {31'd0, irq_o}, 32'd1);
      cfg_write(2'd2, 32'h0000_0016);
      cfg_read(2'd2, v); chk(v[4] == 1'b0, "R10", "pending cleared", v, 32'd0);
      chk(irq_o == 1'b0, "R10", "irq_o after clear", {31'd0, irq_o}, 32'd0);

      // R5: device to memory, 4 words, interrupt disabled
      cfg_write(2'd0, 32'h0000_0040);
      cfg_write(2'd1, 32'd4);
      exp_addr = 64; exp_we = 1'b1; in_idx = 0; in_cnt = 4; acc0 = acc_total;
      cfg_write(2'd2, 32'h0000_0001);
      @(negedge clk);
      cfg_read(2'd2, v); chk(v[3] == 1'b0, "R3", "done cleared by start", v, 32'd0);
      wait_done("R8");
      for (int i = 0; i < 4; i++)
         chk(ram[64 + i] == src_word(i), "R5", "word in memory", ram[64 + i], src_word(i));
      chk(in_idx == 4, "R5", "words taken", in_idx, 4);
      chk(acc_total - acc0 == 4, "R8", "memory accesses", acc_total - acc0, 4);
      cfg_read(2'd2, v); chk(v[4] == 1'b0, "R10", "no pending with enable off", v, 32'd0);
      chk(irq_o == 1'b0, "R10", "irq_o with enable off", {31'd0, irq_o}, 32'd0);

      // R9: zero count
      cfg_write(2'd1, 32'd0);
      acc0 = acc_total;
      cfg_write(2'd2, 32'h0000_0003);
      cfg_read(2'd2, v); chk(v[3] == 1'b1, "R9", "done at once", v, 32'h8);
      repeat (10) @(posedge clk);
      chk(acc_total == acc0, "R9", "no memory access", acc_total - acc0, 0);

      // R3 R11: start and register writes while busy
      cfg_write(2'd0, 32'h0000_0080);
      cfg_write(2'd1, 32'd3);
      dev_hold = 1'b1;
      exp_addr = 128; exp_we = 1'b0; out_base = 128; out_idx = 0; acc0 = acc_total;
      cfg_write(2'd2, 32'h0000_0003);
      repeat (20) @(posedge clk);
      cfg_read(2'd3, v); chk(v == 32'd2, "R6", "count advanced once", v, 32'd2);
      cfg_write(2'd0, 32'h0000_0020);
      cfg_write(2'd1, 32'd9);
      cfg_write(2'd2, 32'h0000_0001);
      cfg_read(2'd3, v); chk(v == 32'd2, "R3", "restart ignored", v, 32'd2);
      dev_hold = 1'b0;
      wait_done("R11");
      chk(out_idx == 3, "R11", "running block kept", out_idx, 3);
      chk(acc_total - acc0 == 3, "R11", "accesses of running block", acc_total - acc0, 3);
      cfg_read(2'd0, v); chk(v == 32'h20, "R11", "new address stored", v, 32'h20);

      // R11: next start uses the new values
      exp_addr = 32; exp_we = 1'b0; out_base = 32; out_idx = 0; acc0 = acc_total;
      cfg_write(2'd2, 32'h0000_0003);
      wait_done("R11");
      chk(out_idx == 9, "R11", "new block length", out_idx, 9);
      chk(acc_total - acc0 == 9, "R8", "memory accesses", acc_total - acc0, 9);

      repeat (5) @(posedge clk);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule